// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Target

This block is a target (slave) on a two-wire serial bus that fronts an internal byte-wide memory. It oversamples the clock line and the open-drain data line with the system clock and spots start and stop conditions. It compares the select byte against a fixed type nibble and three strap inputs, then either takes a two-byte memory address followed by data to store, or returns data. Stores take effect as soon as a byte's eighth bit is in. The bus never waits on the memory and never needs to poll for a busy state.

A persistent address pointer survives from one transaction to the next. A read that is not preceded by an address phase continues from wherever the pointer stands. A random read is formed by sending the address as if for a write, then issuing a repeated start with a read select byte. A write-lock input blocks stores. The memory holds 2^MEM_AW bytes; the full-size instance sets MEM_AW to 13 (8,192 bytes), and the default is smaller to keep elaboration light.

Top module: `twi_byte_ram`

## Requirements
- R1: After reset the data-line drive `sda_oe` is 0 and the address pointer is 0, so a read with no address phase returns the byte at location 0.
- R2: A select byte is acknowledged only when bits 7..4 equal 1010b and bits 3..1 equal `sel_i`; bit 0 picks read (1) or write (0). On a mismatch the block gives no acknowledge, ignores the bus until the next start and leaves the pointer unchanged.
- R3: In a write, the two bytes after the select byte form the address, high byte first; only its low MEM_AW bits are kept and the upper bits are ignored.
- R4: Each data byte of a write is acknowledged, stored at the pointer, and the pointer then advances by one, for any number of bytes.
- R5: The pointer wraps from 2^MEM_AW-1 to 0 on both writes and reads.
- R6: While `wp_i` is 1, a data byte of a write is not acknowledged, not stored and does not advance the pointer; address bytes are still acknowledged.
- R7: A start or stop arriving before the eighth bit of a data byte leaves the memory unchanged.
- R8: A read with no address phase starts at the pointer, which is either the last loaded address or the location after the last byte moved.
- R9: Read data leaves MSB first; an acknowledge from the controller brings the next location, and a no-acknowledge ends the read with the line released.
- R10: An address phase followed by a repeated start and a read select byte returns data from the loaded address.
- R11: A start at any point aborts the current operation and awaits a new select byte; a stop returns the block to idle.
- R12: `sda_oe` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sel_i | input | 3 | Strap value the select byte bits 3..1 must equal |
| wp_i | input | 1 | Write lock: 1 blocks all stores |

## Verification
The checks assume that each level of both bus lines lasts longer than the synchronizer delay plus a few system clocks. They also assume the data line moves while the clock is high only to form a start or stop, and that the controller never tries a start or stop while the block holds the line low. The bench's controller model holds every clock phase for at least six system clocks. It changes its data drive only during the low phase, except in the start and stop tasks. It issues stops only after a no-acknowledge or after the block has released the line, so the synchronized edges the design reacts to are always clean.

// File: rtl/twi_ram_pkg.sv
package twi_ram_pkg;
   localparam int BYTE_W = 8;
   localparam logic [3:0] DEV_TYPE = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WR,
      ST_RD
   } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_q,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   localparam int NLINES = 2;

   initial assert (STAGES >= 2) else $error("twi_line_sync: STAGES below 2");

   logic [NLINES-1:0] raw;
   logic [NLINES-1:0] now_v;
   logic [NLINES-1:0] old_v;

   assign raw = {sda_i, scl_i};

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe     <= '1;
            old_v[g] <= 1'b1;
         end else begin
            pipe     <= {pipe[STAGES-2:0], raw[g]};
            old_v[g] <= pipe[STAGES-1];
         end
      end
      assign now_v[g] = pipe[STAGES-1];
   end

   assign scl_q    = now_v[0];
   assign sda_q    = now_v[1];
   assign scl_rise = now_v[0] & ~old_v[0];
   assign scl_fall = ~now_v[0] & old_v[0];
   assign start_ev = now_v[0] & old_v[0] & ~now_v[1] & old_v[1];
   assign stop_ev  = now_v[0] & old_v[0] & now_v[1] & ~old_v[1];
endmodule

// File: rtl/twi_ram_array.sv
module twi_ram_array #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];
endmodule

// File: rtl/twi_byte_ram.sv
module twi_byte_ram
   import twi_ram_pkg::*;
#(
   parameter int MEM_AW      = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [2:0] sel_i,
   input  logic       wp_i
);
   localparam int CNT_W = 4;

   initial assert (MEM_AW >= 8 && MEM_AW <= 16)
      else $error("twi_byte_ram: MEM_AW out of 8..16");

   logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_q    (scl_q),
      .sda_q    (sda_q),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   twi_state_e         st, st_next;
   logic               in_ack, ack_go, rd_mode;
   logic [CNT_W-1:0]   bcnt;
   logic [BYTE_W-1:0]  shreg, ahi, tx, byte_nxt, rd_byte;
   logic [MEM_AW-1:0]  addr_q;
   logic               byte_ok, last_bit, mem_we;

   twi_ram_array #(.AW(MEM_AW), .DW(BYTE_W)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .addr  (addr_q),
      .wdata (byte_nxt),
      .rdata (rd_byte)
   );

   assign byte_nxt = {shreg[BYTE_W-2:0], sda_q};
   assign last_bit = scl_rise && !in_ack && !ack_go && (bcnt == CNT_W'(BYTE_W-1))
                     && !start_ev && !stop_ev;

   always_comb begin
      unique case (st)
         ST_DEV:  byte_ok = (byte_nxt[7:4] == DEV_TYPE) && (byte_nxt[3:1] == sel_i);
         ST_WR:   byte_ok = !wp_i;
         default: byte_ok = 1'b1;
      endcase
   end

   always_comb begin
      unique case (st)
         ST_DEV:        st_next = rd_mode ? ST_RD : ST_AHI;
         ST_AHI:        st_next = ST_ALO;
         ST_ALO, ST_WR: st_next = ST_WR;
         default:       st_next = ST_IDLE;
      endcase
   end

   assign mem_we = (st == ST_WR) && last_bit && !wp_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         in_ack  <= 1'b0;
         ack_go  <= 1'b0;
         rd_mode <= 1'b0;
         bcnt    <= '0;
         shreg   <= '0;
         ahi     <= '0;
         tx      <= '0;
         addr_q  <= '0;
         sda_oe  <= 1'b0;
      end else if (start_ev || stop_ev) begin
         st     <= start_ev ? ST_DEV : ST_IDLE;
         in_ack <= 1'b0;
         ack_go <= 1'b0;
         bcnt   <= '0;
         sda_oe <= 1'b0;
      end else if (st == ST_RD) begin
         if (!in_ack) begin
            if (scl_rise) bcnt <= bcnt + 1'b1;
            if (last_bit) addr_q <= addr_q + MEM_AW'(1);
            if (scl_fall) begin
               if (bcnt == CNT_W'(BYTE_W)) begin
                  sda_oe <= 1'b0;
                  in_ack <= 1'b1;
               end else begin
                  sda_oe <= ~tx[3'd7 - bcnt[2:0]];
               end
            end
         end else begin
            if (scl_rise && sda_q) st <= ST_IDLE;
            if (scl_fall) begin
               in_ack <= 1'b0;
               bcnt   <= '0;
               tx     <= rd_byte;
               sda_oe <= ~rd_byte[BYTE_W-1];
            end
         end
      end else if (st != ST_IDLE) begin
         if (!in_ack) begin
            if (scl_rise && !ack_go) begin
               shreg <= byte_nxt;
               bcnt  <= bcnt + 1'b1;
            end
            if (last_bit) begin
               if (byte_ok) ack_go <= 1'b1;
               else         st     <= ST_IDLE;
               unique case (st)
                  ST_DEV:  rd_mode <= byte_nxt[0];
                  ST_AHI:  ahi     <= byte_nxt;
                  ST_ALO:  addr_q  <= MEM_AW'({ahi, byte_nxt});
                  ST_WR:   if (byte_ok) addr_q <= addr_q + MEM_AW'(1);
                  default: ;
               endcase
            end
            if (scl_fall && ack_go) begin
               ack_go <= 1'b0;
               in_ack <= 1'b1;
               sda_oe <= 1'b1;
            end
         end else if (scl_fall) begin
            in_ack <= 1'b0;
            bcnt   <= '0;
            st     <= st_next;
            if (st == ST_DEV && rd_mode) begin
               tx     <= rd_byte;
               sda_oe <= ~rd_byte[BYTE_W-1];
            end else begin
               sda_oe <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/twi_ram_chk.sv
module twi_ram_chk
   import twi_ram_pkg::*;
#(
   parameter int MEM_AW = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_q,
   input logic              start_ev,
   input logic              stop_ev,
   input logic              sda_oe,
   input logic              wp_i,
   input twi_state_e        st,
   input logic [MEM_AW-1:0] addr_q
);
   // R12
   oe_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_q);

   // R11
   start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (st == ST_DEV && !sda_oe));

   // R11
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (st == ST_IDLE));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_q != $past(addr_q)) |->
         (addr_q == MEM_AW'($past(addr_q) + 1'b1)) || ($past(st) == ST_ALO));

   // R6
   wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WR && wp_i) |=> $stable(addr_q));
endmodule

bind twi_byte_ram twi_ram_chk #(.MEM_AW(MEM_AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_q    (scl_q),
   .start_ev (start_ev),
   .stop_ev  (stop_ev),
   .sda_oe   (sda_oe),
   .wp_i     (wp_i),
   .st       (st),
   .addr_q   (addr_q)
);

// File: tb/tb_twi_byte_ram.sv
`timescale 1ns/1ps
module tb_twi_byte_ram;
   localparam int AW  = 11;
   localparam int TOP = (1 << AW) - 1;
   localparam int Q   = 6;
   localparam int H   = 12;
   localparam logic [7:0] DEV_W = 8'hAA;
   localparam logic [7:0] DEV_R = 8'hAB;

   logic clk = 0;
   logic rst_n = 0;
   logic m_scl = 1, m_sda = 1;
   logic wp = 0;
   logic sda_oe;
   wire  sda_bus = m_sda & ~sda_oe;

   int checks = 0, errors = 0, r12_bad = 0;
   bit done = 0;
   logic prev_oe = 0;

   always #4 clk = ~clk;

   twi_byte_ram #(.MEM_AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .sel_i(3'b101), .wp_i(wp));

   always @(negedge clk) begin
      if (sda_oe !== prev_oe && m_scl) r12_bad++;
      prev_oe = sda_oe;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bstart();
      m_sda = 1; tick(Q); m_scl = 1; tick(H); m_sda = 0; tick(H); m_scl = 0; tick(Q);
   endtask

   task automatic bstop();
      m_sda = 0; tick(Q); m_scl = 1; tick(H); m_sda = 1; tick(H);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_sda = b[i]; tick(Q); m_scl = 1; tick(H); m_scl = 0; tick(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      send_bits(b, 8);
      m_sda = 1; tick(Q); m_scl = 1; tick(H/2);
      acked = (sda_bus == 1'b0);
      tick(H/2); m_scl = 0; tick(Q);
   endtask

   task automatic recv_byte(output logic [7:0] b, input bit give_ack);
      m_sda = 1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q); m_scl = 1; tick(H/2); b[i] = sda_bus; tick(H/2); m_scl = 0;
      end
      m_sda = give_ack ? 1'b0 : 1'b1;
      tick(Q); m_scl = 1; tick(H); m_scl = 0; m_sda = 1; tick(Q);
   endtask

   task automatic addr_phase(input logic [15:0] a, input string req);
      bit k;
      bstart();
      send_byte(DEV_W, k); chk(k, "R2", k, 1);
      send_byte(a[15:8], k); chk(k, req, k, 1);
      send_byte(a[7:0], k);  chk(k, req, k, 1);
   endtask

   task automatic read_one(output logic [7:0] d);
      bit k;
      bstart();
      send_byte(DEV_R, k); chk(k, "R8", k, 1);
      recv_byte(d, 0);
      bstop();
   endtask

   task automatic t_reset();
      chk(sda_oe == 0, "R1", sda_oe, 0);
   endtask

   task automatic t_write_burst();
      bit k;
      logic [7:0] d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
      addr_phase(16'h0010, "R3");
      for (int i = 0; i < 4; i++) begin
         send_byte(d[i], k); chk(k, "R4", k, 1);
      end
      bstop();
   endtask

   task automatic t_selective_read();
      bit k;
      logic [7:0] r;
      addr_phase(16'h0010, "R10");
      bstart();
      send_byte(DEV_R, k); chk(k, "R10", k, 1);
      recv_byte(r, 1); chk(r == 8'h11, "R10", r, 8'h11);
      recv_byte(r, 1); chk(r == 8'h22, "R9", r, 8'h22);
      recv_byte(r, 0); chk(r == 8'h33, "R9", r, 8'h33);
      tick(Q); chk(sda_oe == 0, "R9 released", sda_oe, 0);
      bstop();
   endtask

   task automatic t_current_read();
      logic [7:0] r;
      read_one(r); chk(r == 8'h44, "R8", r, 8'h44);
   endtask

   task automatic t_upper_ignored();
      bit k;
      logic [7:0] r;
      addr_phase(16'hF805, "R3");
      send_byte(8'h5A, k); chk(k, "R4", k, 1);
      bstop();
      addr_phase(16'h0005, "R3");
      bstart(); send_byte(DEV_R, k);
      recv_byte(r, 0); bstop();
      chk(r == 8'h5A, "R3 upper bits", r, 8'h5A);
   endtask

   task automatic t_wrap();
      bit k;
      logic [7:0] r;
      addr_phase(16'(TOP), "R5");
      send_byte(8'hA1, k); send_byte(8'hB2, k); bstop();
      addr_phase(16'(TOP), "R5");
      bstart(); send_byte(DEV_R, k);
      recv_byte(r, 1); chk(r == 8'hA1, "R5", r, 8'hA1);
      recv_byte(r, 0); chk(r == 8'hB2, "R5 wrap", r, 8'hB2);
      bstop();
   endtask

   task automatic t_prep();
      bit k;
      addr_phase(16'h0020, "R3");
      send_byte(8'h77, k); send_byte(8'h78, k); bstop();
      addr_phase(16'h0030, "R3");
      send_byte(8'h3C, k); send_byte(8'hC3, k); bstop();
   endtask

   task automatic t_write_protect();
      bit k;
      logic [7:0] r;
      wp = 1;
      addr_phase(16'h0020, "R6");
      send_byte(8'h99, k); chk(!k, "R6 no ack", k, 0);
      bstop();
      wp = 0;
      read_one(r); chk(r == 8'h77, "R6 no store no step", r, 8'h77);
   endtask

   task automatic t_mismatch();
      bit k;
      logic [7:0] r;
      bstart();
      send_byte(8'hA8, k); chk(!k, "R2 strap", k, 0);
      send_byte(8'h00, k); chk(!k && sda_oe == 0, "R2 ignored", k, 0);
      bstart();
      send_byte(8'hBA, k); chk(!k, "R2 type", k, 0);
      bstop();
      read_one(r); chk(r == 8'h78, "R2 pointer kept", r, 8'h78);
   endtask

   task automatic t_abort_partial();
      bit k;
      logic [7:0] r;
      addr_phase(16'h0030, "R7");
      send_bits(8'hFF, 5);
      bstop();
      read_one(r); chk(r == 8'h3C, "R7 stop", r, 8'h3C);
      addr_phase(16'h0030, "R7");
      send_bits(8'h00, 3);
      bstart();
      send_byte(DEV_R, k); chk(k, "R11", k, 1);
      recv_byte(r, 0); bstop();
      chk(r == 8'h3C, "R7 start", r, 8'h3C);
   endtask

   task automatic t_start_midaddr();
      bit k;
      logic [7:0] r;
      bstart();
      send_byte(DEV_W, k); send_byte(8'h00, k);
      bstart();
      send_byte(DEV_R, k); chk(k, "R11", k, 1);
      recv_byte(r, 0); bstop();
      chk(r == 8'hC3, "R11 abort", r, 8'hC3);
   endtask

   task automatic t_reset_pointer();
      logic [7:0] r;
      rst_n = 0; tick(4); rst_n = 1; tick(4);
      read_one(r); chk(r == 8'hB2, "R1 pointer zero", r, 8'hB2);
   endtask

   initial begin
      tick(5); rst_n = 1; tick(5);
      t_reset();
      t_write_burst();
      t_selective_read();
      t_current_read();
      t_upper_ignored();
      t_wrap();
      t_prep();
      t_write_protect();
      t_mismatch();
      t_abort_partial();
      t_start_midaddr();
      t_reset_pointer();
      chk(r12_bad == 0, "R12", r12_bad, 0);
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule